// File: doc/BRIEF.md
# Priority-Grouped Least-Recently-Granted Arbiter

This block chooses one of N masters that compete for a single slave port. Every master has a programmable priority value and one place in a shared ordering. Masters that hold the same value form a group. The grant goes to the group with the highest value among the masters that are requesting. Inside that group, the requester placed highest in the ordering wins. When a grant is accepted, the winner drops to the bottom of its group.

If every master has its own priority value, the block acts as a fixed-priority encoder. If all values are equal, it acts as a least-recently-granted arbiter. Any mix of the two is allowed. Priority values start from a parameter at reset and are read and written through an APB slave port, one register per master. The grant is combinational from the requests and the registered state. The ordering changes only on the clock edge of an accepted grant or of a priority change.

Top module: `lrg_prio_arbiter`

## Requirements
- R1: After reset, master i's priority equals bits [i*PW +: PW] of RESET_PRIO. The ordering in every group is ascending master index, with index 0 at the top.
- R2: At most one `gnt` bit is high, and only for a master whose `req` bit is set. `gnt_valid` is high exactly when any `req` bit is set. When it is high, `gnt` equals one shifted left by `gnt_idx`.
- R3: A larger numeric priority value beats a smaller one. The winner always comes from the highest-valued group that has a request.
- R4: Within the winning group, the requesting master highest in the current ordering wins.
- R5: On a clock edge where `gnt_valid` and `gnt_ack` are both high, the winner moves to the bottom of its group. The other members of that group, and all other groups, keep their relative order.
- R6: With `gnt_ack` low or no request pending, the ordering does not change, and the same requests give the same grant in the next cycle.
- R7: When all priority values are distinct, the grant depends only on the priority values and never on the grant history.
- R8: When all priority values are equal, a master requesting continuously is granted within N accepted grants, in round-robin order starting from the least recently granted.
- R9: A read with `paddr` = i (i < N) returns master i's priority in the low PW bits of `prdata` during the setup and access phases. A read with `paddr` >= N returns zero. A write in the access phase (`psel`, `penable` and `pwrite` all high) with `paddr` < N stores `pwdata[PW-1:0]`. `pready` is always high.
- R10: A grant computed in the same cycle as a priority write uses the old value. The new value applies from the next cycle.
- R11: A master whose priority changes to a different value joins its new group at the bottom of that group's order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | N | Request, one bit per master |
| gnt_ack | input | 1 | The current grant is taken this cycle |
| gnt | output | N | One-hot grant |
| gnt_valid | output | 1 | A grant is issued |
| gnt_idx | output | IW | Index of the granted master |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable |
| pwrite | input | 1 | APB write |
| paddr | input | AW | APB register index (master number) |
| pwdata | input | DW | APB write data |
| prdata | output | DW | APB read data |
| pready | output | 1 | APB ready, always high |

## Verification
The bench targets several corner cases:
- Two groups are interleaved. A design that reorders globally instead of per group would give the lower group the wrong winner after the upper group is served.
- A write lands in the same cycle as an arbitration. A design that forwards the new value would grant the wrong master in that cycle.
- A master is reprogrammed and then returned to its old group. A design that kept its old place would grant it first instead of last.
- The acknowledge is held low. A design that rotates on every grant, accepted or not, would move the winner.

// File: rtl/lrg_prio_arbiter.sv
module lrg_prio_arbiter #(
  parameter int N = 4,
  parameter int PW = 2,
  parameter int AW = 4,
  parameter int DW = 32,
  parameter logic [N*PW-1:0] RESET_PRIO = '0,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          gnt_ack,
  output logic [N-1:0]  gnt,
  output logic          gnt_valid,
  output logic [IW-1:0] gnt_idx,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [DW-1:0] pwdata,
  output logic [DW-1:0] prdata,
  output logic          pready
);

  logic [N-1:0][PW-1:0] prio_q;
  logic [N-1:0][IW-1:0] rank_q, rank_d;
  logic                 win_found;
  logic [IW-1:0]        win_idx;
  logic [PW-1:0]        best_p;
  logic [IW-1:0]        best_r;

  logic          in_range, wr_en, wr_chg;
  logic [IW-1:0] reg_idx;
  logic          unused_ok;

  assign in_range  = int'(paddr) < N;
  assign reg_idx   = paddr[IW-1:0];
  assign wr_en     = psel && penable && pwrite && in_range;
  assign wr_chg    = wr_en && (pwdata[PW-1:0] != prio_q[reg_idx]);
  assign unused_ok = ^pwdata[DW-1:PW];

  always_comb begin
    win_found = 1'b0;
    win_idx   = '0;
    best_p    = '0;
    best_r    = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && (!win_found || prio_q[i] > best_p ||
                     (prio_q[i] == best_p && rank_q[i] < best_r))) begin
        win_found = 1'b1;
        win_idx   = IW'(i);
        best_p    = prio_q[i];
        best_r    = rank_q[i];
      end
    end
  end

  assign gnt_valid = win_found;
  assign gnt_idx   = win_idx;
  assign gnt       = win_found ? (N'(1) << win_idx) : '0;

  function automatic logic [N-1:0][IW-1:0] relegate(
    input logic [N-1:0][IW-1:0] r, input logic [IW-1:0] t);
    relegate = r;
    for (int j = 0; j < N; j++) begin
      if (IW'(j) == t)      relegate[j] = IW'(N-1);
      else if (r[j] > r[t]) relegate[j] = r[j] - 1'b1;
    end
  endfunction

  always_comb begin
    rank_d = rank_q;
    if (win_found && gnt_ack) rank_d = relegate(rank_d, win_idx);
    if (wr_chg)               rank_d = relegate(rank_d, reg_idx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        rank_q[i] <= IW'(i);
        prio_q[i] <= RESET_PRIO[i*PW +: PW];
      end
    end else begin
      rank_q <= rank_d;
      if (wr_en) prio_q[reg_idx] <= pwdata[PW-1:0];
    end
  end

  assign prdata = (psel && !pwrite && in_range) ? DW'(prio_q[reg_idx]) : '0;
  assign pready = 1'b1;

endmodule

// File: rtl/lrg_prio_arbiter_chk.sv
module lrg_prio_arbiter_chk #(
  parameter int N = 4,
  parameter int IW = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [N-1:0]         req,
  input logic                 gnt_ack,
  input logic [N-1:0]         gnt,
  input logic                 gnt_valid,
  input logic [IW-1:0]        gnt_idx,
  input logic                 psel,
  input logic                 penable,
  input logic                 pwrite,
  input logic [N-1:0][IW-1:0] rank
);

  logic apb_wr;
  assign apb_wr = psel && penable && pwrite;

  // R2
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  // R2
  gnt_to_requester_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);

  // R2
  gnt_when_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid == (|req));

  // R5
  winner_to_bottom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && gnt_ack && !apb_wr) |=> rank[$past(gnt_idx)] == IW'(N-1));

  // R6
  order_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(gnt_valid && gnt_ack) && !apb_wr) |=> $stable(rank));

endmodule

bind lrg_prio_arbiter lrg_prio_arbiter_chk #(.N(N), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .gnt_ack(gnt_ack), .gnt(gnt),
  .gnt_valid(gnt_valid), .gnt_idx(gnt_idx), .psel(psel), .penable(penable),
  .pwrite(pwrite), .rank(rank_q)
);

// File: tb/test_lrg_prio_arbiter.sv
module test_lrg_prio_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4, PW = 2, AW = 4, DW = 32, IW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req = '0;
  logic          gnt_ack = 1'b0;
  logic [N-1:0]  gnt;
  logic          gnt_valid;
  logic [IW-1:0] gnt_idx;
  logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [AW-1:0] paddr = '0;
  logic [DW-1:0] pwdata = '0;
  logic [DW-1:0] prdata;
  logic          pready;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lrg_prio_arbiter #(.N(N), .PW(PW), .AW(AW), .DW(DW), .RESET_PRIO('0)) i_lrg_prio_arbiter (
    .clk(clk), .rst_n(rst_n), .req(req), .gnt_ack(gnt_ack), .gnt(gnt),
    .gnt_valid(gnt_valid), .gnt_idx(gnt_idx), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req = '0; gnt_ack = 1'b0; psel = 1'b0; penable = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic step(input logic [N-1:0] r, input logic a, input int exp, input string tag);
    @(negedge clk);
    req = r; gnt_ack = a;
    #1;
    check({tag, " gnt_idx"}, gnt_idx, exp);
    check({tag, " gnt"}, gnt, 1 << exp);
  endtask

  task automatic apb_write(input int idx, input int val);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0;
    paddr = AW'(idx); pwdata = DW'(val);
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_read_check(input int idx, input int exp, input string tag);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = AW'(idx);
    #1;
    check({tag, " prdata"}, prdata, exp);
    @(negedge clk);
    penable = 1'b1;
    #1;
    check({tag, " pready"}, pready, 1);
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    for (int i = 0; i < N; i++) apb_read_check(i, 0, "R1 reset prio");
    apb_read_check(5, 0, "R9 out of range read");
    step(4'b1111, 1'b0, 0, "R1 reset order top");
  endtask

  task automatic t_lrg();
    do_reset();
    step(4'b1111, 1'b1, 0, "R8 lrg");
    step(4'b1111, 1'b1, 1, "R8 lrg");
    step(4'b1111, 1'b1, 2, "R8 lrg");
    step(4'b1111, 1'b1, 3, "R8 lrg");
    step(4'b1111, 1'b1, 0, "R8 lrg wrap");
    step(4'b1010, 1'b1, 1, "R4 subset order");
  endtask

  task automatic t_no_ack();
    do_reset();
    step(4'b1111, 1'b0, 0, "R6 ack low");
    step(4'b1111, 1'b0, 0, "R6 ack low hold");
    @(negedge clk);
    req = '0;
    #1;
    check("R2 idle gnt_valid", gnt_valid, 0);
    check("R2 idle gnt", gnt, 0);
    step(4'b1111, 1'b1, 0, "R6 idle keeps order");
  endtask

  task automatic t_fixed();
    do_reset();
    apb_write(1, 1); apb_write(2, 2); apb_write(3, 3);
    apb_read_check(3, 3, "R9 readback");
    step(4'b1111, 1'b1, 3, "R7 fixed");
    step(4'b1111, 1'b1, 3, "R7 fixed repeat");
    step(4'b0011, 1'b1, 1, "R3 fixed");
    step(4'b0011, 1'b1, 1, "R7 fixed history");
    step(4'b0101, 1'b1, 2, "R3 fixed");
  endtask

  task automatic t_mixed();
    do_reset();
    apb_write(2, 2); apb_write(3, 2);
    step(4'b1111, 1'b1, 2, "R3 mixed high group");
    step(4'b0011, 1'b1, 0, "R5 low group");
    step(4'b1111, 1'b1, 3, "R5 high group rotates");
    step(4'b0011, 1'b1, 1, "R5 low group rotates");
    step(4'b1111, 1'b1, 2, "R5 high group wraps");
    step(4'b0011, 1'b1, 0, "R5 low group wraps");
  endtask

  task automatic t_same_cycle();
    do_reset();
    @(negedge clk);
    req = 4'b1001; gnt_ack = 1'b0;
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = 3; pwdata = 3;
    @(negedge clk);
    penable = 1'b1;
    #1;
    check("R10 old value used", gnt_idx, 0);
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    #1;
    check("R10 new value next cycle", gnt_idx, 3);
  endtask

  task automatic t_rejoin();
    do_reset();
    apb_write(0, 1);
    step(4'b1111, 1'b0, 0, "R11 own group");
    apb_write(0, 0);
    step(4'b1111, 1'b1, 1, "R11 rejoin bottom");
    step(4'b1111, 1'b1, 2, "R11 rejoin bottom");
    step(4'b1111, 1'b1, 3, "R11 rejoin bottom");
    step(4'b1111, 1'b1, 0, "R11 rejoin last");
  endtask

  initial begin
    t_reset();
    t_lrg();
    t_no_ack();
    t_fixed();
    t_mixed();
    t_same_cycle();
    t_rejoin();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule